// File: doc/BRIEF.md
# Edge Port Interrupt Flag Unit

This block watches seven external interrupt pins, numbered 1 to 7. Each pin passes through a two-stage synchroniser. It is then either used as an active-low level request or examined for edges, according to a 2-bit sensitivity field per pin. Detected edges set sticky flags. The flags stay set until software writes a 1 to the matching bit. Each pin also has an enable input. The block drives one interrupt request per pin, which is passed on to an external priority arbiter.

Software reaches the block through a small register bus with one-cycle access. Two locations are mapped:

- A read-only pin-state register at offset 0x5. It shows the current synchronised pin levels, and reset does not change it.
- The flag register at offset 0x6.

In both registers pin n sits at bit n, and bit 0 is reserved.

Top module: `edge_flag_unit`

## Requirements
- R1: A read at offset 0x5 returns the synchronised level of pin n (extPin[n-1]) in bit n for n = 1..7, and bit 0 reads 0.
- R2: Every access with busSel high is answered with busReady high in the following cycle, with read data valid in that same cycle. A write to offset 0x5 changes nothing.
- R3: Reset does not force the pin-state register: a read right after reset returns the pin levels that were held during reset.
- R4: A read at offset 0x6 returns the flag of pin n in bit n, with bit 0 reading 0. Reset clears every flag.
- R5: With sensitivity 01 (rising), a low-to-high pin transition sets the pin's flag and a high-to-low transition does not.
- R6: With sensitivity 10 (falling), a high-to-low transition sets the flag and a low-to-high transition does not.
- R7: With sensitivity 11 (both), either transition sets the flag.
- R8: With sensitivity 00 (level), no pin transition ever sets the flag.
- R9: Writing offset 0x6 clears each flag whose bit in the write data is 1. Bits written as 0 leave their flags unchanged.
- R10: If an edge is detected in the same cycle as a write of 1 that clears the same flag, the flag stays set.
- R11: For a pin in an edge mode, irqReq[n-1] equals enable AND flag.
- R12: For a pin in level mode, irqReq[n-1] equals enable AND NOT the synchronised pin level.
- R13: Reads at any offset other than 0x5 and 0x6 return 0, and writes there change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| extPin | input | 7 | External pins; bit i carries pin i+1 |
| senseCfg | input | 14 | Sensitivity per pin, bits [2i+1:2i] for pin i+1 (00 level, 01 rise, 10 fall, 11 both) |
| irqEnable | input | 7 | Request enable per pin |
| busSel | input | 1 | Bus access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Register offset |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid with busReady |
| busReady | output | 1 | Access completion, one cycle after busSel |
| irqReq | output | 7 | Interrupt request per pin |

## Verification
One pin pattern and its inverse are applied with the four sensitivity modes spread across the pins. In a single step, this shows which modes react to rising edges, which to falling edges and which to neither. A level-mode pin is toggled to show that transitions never reach its flag, while its request still follows the pin level. Clear writes use mixed masks, including an all-zero mask, to tell per-bit clearing apart from whole-register clearing. A clear write is also timed to land in the exact cycle an edge is detected, which separates the set-wins rule from a clear-wins rule.

// File: rtl/epu_pkg.sv
package epu_pkg;
  typedef enum logic [1:0] {
    SENSE_LEVEL = 2'b00,
    SENSE_RISE  = 2'b01,
    SENSE_FALL  = 2'b10,
    SENSE_BOTH  = 2'b11
  } sense_e;

  typedef struct packed {
    logic rdPins;
    logic rdFlags;
    logic clrFlags;
  } strobe_t;
endpackage

// File: rtl/epu_ctrl.sv
module epu_ctrl
  import epu_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int PIN_OFS  = 5,
  parameter int FLAG_OFS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strobe,
  output logic              busReady
);
  localparam logic [ADDR_W-1:0] PinAddr  = ADDR_W'(PIN_OFS);
  localparam logic [ADDR_W-1:0] FlagAddr = ADDR_W'(FLAG_OFS);

  logic readyQ;

  always_comb begin
    strobe.rdPins   = busSel && !busWrite && (busAddr == PinAddr);
    strobe.rdFlags  = busSel && !busWrite && (busAddr == FlagAddr);
    strobe.clrFlags = busSel &&  busWrite && (busAddr == FlagAddr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) readyQ <= 1'b0;
    else        readyQ <= busSel;
  end

  assign busReady = readyQ;

  // R2: every access completes in the next cycle
  assert_ready_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busSel |=> busReady);
  assert_ready_needs_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busSel |=> !busReady);
endmodule

// File: rtl/epu_datapath.sv
module epu_datapath
  import epu_pkg::*;
#(
  parameter int PIN_CNT = 7,
  parameter int REG_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PIN_CNT-1:0] extPin,
  input  logic [2*PIN_CNT-1:0] senseCfg,
  input  logic [PIN_CNT-1:0] irqEnable,
  input  strobe_t            strobe,
  input  logic [REG_W-1:0]   busWdata,
  output logic [REG_W-1:0]   busRdata,
  output logic [PIN_CNT-1:0] irqReq
);
  logic [PIN_CNT-1:0] syncA, syncB, prevB;
  logic [PIN_CNT-1:0] flagQ, edgeHit, clrMask, levelMode;
  logic [REG_W-1:0]   pinWord, flagWord, rdataQ;
  logic               unusedWdata;

  assign unusedWdata = busWdata[0];

  // Synchroniser and history; deliberately free of reset (R3)
  always_ff @(posedge clk) begin
    syncA <= extPin;
    syncB <= syncA;
    prevB <= syncB;
  end

  assign clrMask = strobe.clrFlags ? busWdata[PIN_CNT:1] : '0;

  for (genvar i = 0; i < PIN_CNT; i++) begin : gPin
    sense_e mode;
    logic   rise, fall;
    assign mode = sense_e'(senseCfg[2*i +: 2]);
    assign rise = syncB[i] & ~prevB[i];
    assign fall = ~syncB[i] & prevB[i];
    assign levelMode[i] = (mode == SENSE_LEVEL);

    always_comb begin
      unique case (mode)
        SENSE_RISE: edgeHit[i] = rise;
        SENSE_FALL: edgeHit[i] = fall;
        SENSE_BOTH: edgeHit[i] = rise | fall;
        default:    edgeHit[i] = 1'b0;
      endcase
    end

    // Set dominates clear (R10)
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flagQ[i] <= 1'b0;
      else        flagQ[i] <= (flagQ[i] & ~clrMask[i]) | edgeHit[i];
    end

    assign irqReq[i] = irqEnable[i] & (levelMode[i] ? ~syncB[i] : flagQ[i]);

    assert_level_no_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (levelMode[i] && !flagQ[i]) |=> !flagQ[i]);
    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flagQ[i] && !clrMask[i]) |=> flagQ[i]);
    assert_clear_works_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clrMask[i] && !edgeHit[i]) |=> !flagQ[i]);
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      edgeHit[i] |=> flagQ[i]);
    assert_irq_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !irqEnable[i] |-> !irqReq[i]);
  end

  always_comb begin
    pinWord  = '0;
    flagWord = '0;
    pinWord[PIN_CNT:1]  = syncB;
    flagWord[PIN_CNT:1] = flagQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              rdataQ <= '0;
    else if (strobe.rdPins)  rdataQ <= pinWord;
    else if (strobe.rdFlags) rdataQ <= flagWord;
    else                     rdataQ <= '0;
  end

  assign busRdata = rdataQ;

  assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busRdata[0]);
endmodule

// File: rtl/edge_flag_unit.sv
module edge_flag_unit
  import epu_pkg::*;
#(
  parameter int PIN_CNT  = 7,
  parameter int REG_W    = 8,
  parameter int ADDR_W   = 3,
  parameter int PIN_OFS  = 5,
  parameter int FLAG_OFS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PIN_CNT-1:0]   extPin,
  input  logic [2*PIN_CNT-1:0] senseCfg,
  input  logic [PIN_CNT-1:0]   irqEnable,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [REG_W-1:0]     busWdata,
  output logic [REG_W-1:0]     busRdata,
  output logic                 busReady,
  output logic [PIN_CNT-1:0]   irqReq
);
  strobe_t strobe;

  epu_ctrl #(
    .ADDR_W(ADDR_W), .PIN_OFS(PIN_OFS), .FLAG_OFS(FLAG_OFS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .strobe(strobe), .busReady(busReady)
  );

  epu_datapath #(
    .PIN_CNT(PIN_CNT), .REG_W(REG_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .extPin(extPin), .senseCfg(senseCfg),
    .irqEnable(irqEnable), .strobe(strobe), .busWdata(busWdata),
    .busRdata(busRdata), .irqReq(irqReq)
  );
endmodule

// File: tb/sim_edge_flag_unit.sv
module sim_edge_flag_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [6:0] extPin = 7'h55;
  logic [13:0] senseCfg;
  logic [6:0] irqEnable = 7'h7D;
  logic       busSel = 0, busWrite = 0;
  logic [2:0] busAddr = 0;
  logic [7:0] busWdata = 0;
  logic [7:0] busRdata;
  logic       busReady;
  logic [6:0] irqReq;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [6:0] expFlags = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_flag_unit u0 (
    .clk(clk), .rst_n(rst_n), .extPin(extPin), .senseCfg(senseCfg),
    .irqEnable(irqEnable), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busReady(busReady), .irqReq(irqReq)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard when a completed read appears
  always @(negedge clk) begin
    if (busReady && expQ.size() > 0) begin
      chk(tagQ.pop_front(), busRdata, expQ.pop_front());
    end
  end

  task automatic busRd(logic [2:0] addr, logic [7:0] exp, string tag);
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = addr;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    busSel = 0;
    @(negedge clk);
  endtask

  task automatic busWr(logic [2:0] addr, logic [7:0] data, string tag);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = addr; busWdata = data;
    @(negedge clk);
    busSel = 0; busWrite = 0;
    chk(tag, {7'd0, busReady}, 8'd1);
  endtask

  function automatic logic [6:0] hitOf(logic [6:0] oldV, logic [6:0] newV);
    logic [6:0] h = 0;
    for (int i = 0; i < 7; i++) begin
      logic r = ~oldV[i] & newV[i];
      logic f = oldV[i] & ~newV[i];
      case (senseCfg[2*i +: 2])
        2'b01: h[i] = r;
        2'b10: h[i] = f;
        2'b11: h[i] = r | f;
        default: h[i] = 1'b0;
      endcase
    end
    return h;
  endfunction

  task automatic setPins(logic [6:0] v);
    @(negedge clk);
    expFlags = expFlags | hitOf(extPin, v);
    extPin = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic chkIrq(string tag);
    logic [6:0] e;
    for (int i = 0; i < 7; i++)
      e[i] = irqEnable[i] & ((senseCfg[2*i +: 2] == 2'b00) ? ~extPin[i] : expFlags[i]);
    chk(tag, {1'b0, irqReq}, {1'b0, e});
  endtask

  initial begin
    // pin1 level, pin2 rise, pin3 fall, pin4 both, pins5..7 rise
    senseCfg = {2'b01, 2'b01, 2'b01, 2'b11, 2'b10, 2'b01, 2'b00};
    repeat (5) @(negedge clk);
    rst_n = 1;
    busRd(3'd6, 8'h00, "R4 flags clear after reset");
    busRd(3'd5, 8'hAA, "R3 pin state survives reset");
    busWr(3'd5, 8'hFF, "R2 write to pin register completes");
    busRd(3'd5, 8'hAA, "R2 pin register write ignored");
    busRd(3'd0, 8'h00, "R13 unmapped read is zero");
    chkIrq("R12 level request after reset");

    setPins(7'h2A);
    busRd(3'd5, {7'h2A, 1'b0}, "R1 pin state inverse pattern");
    busRd(3'd6, {expFlags, 1'b0}, "R5 R6 R7 R8 flags after first toggle");
    chk("R8 level pin flag clear", {7'd0, expFlags[0]}, 8'd0);
    chkIrq("R11 R12 requests after first toggle");

    setPins(7'h55);
    busRd(3'd6, {expFlags, 1'b0}, "R5 R6 R7 flags after second toggle");
    chkIrq("R12 level pin high gives no request");

    busWr(3'd6, 8'h00, "R9 zero write completes");
    busRd(3'd6, {expFlags, 1'b0}, "R9 writing zeros keeps flags");
    busWr(3'd6, 8'h0C, "R9 mask write completes");
    expFlags &= ~7'h06;
    busRd(3'd6, {expFlags, 1'b0}, "R9 selected flags cleared");
    busWr(3'd1, 8'hFE, "R13 unmapped write completes");
    busRd(3'd6, {expFlags, 1'b0}, "R13 unmapped write leaves flags");
    chkIrq("R11 requests follow flags");

    // R10: clear lands in the edge-detect cycle of pin2
    @(negedge clk);
    extPin[1] = 1'b1;
    expFlags[1] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = 3'd6; busWdata = 8'h04;
    @(negedge clk);
    busSel = 0; busWrite = 0;
    repeat (3) @(negedge clk);
    busRd(3'd6, {expFlags, 1'b0}, "R10 edge beats simultaneous clear");
    busWr(3'd6, 8'h04, "R9 plain clear completes");
    expFlags[1] = 1'b0;
    busRd(3'd6, {expFlags, 1'b0}, "R9 plain clear takes effect");

    setPins(7'h54);
    chkIrq("R12 level pin low raises request");
    busRd(3'd6, {expFlags, 1'b0}, "R8 level pin toggle sets nothing");
    busRd(3'd5, 8'hA8, "R1 pin state after level toggle");

    repeat (3) @(negedge clk);
    chk("scoreboard drained", 8'(expQ.size()), 8'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule